// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block is the control state machine that sits between a software-visible control word and a byte-level I2C bus engine. Software writes a control word (enable, master, direction, repeat, stop and start bits), a byte count and a 7-bit target address. On a start it asks the bus engine for a start condition with the address, then moves bytes between its two small byte queues and the bus. When the count runs out it either requests a stop or reports that the access is ready. It clears the start, stop and master bits by itself as each phase completes.

A repeat mode ignores the count. Each time it runs, it drains the transmit queue or fetches a byte, and it closes the transfer as soon as a stop is pending. Four events are reported: missing acknowledge, transmit data wanted, receive data available and access ready. The bus engine handshake is simple. The request and operation are held until a one-cycle done pulse, which returns the acknowledge bit and any received byte.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write keeps only the bits in mask 0xcf87, with bit 15 enable, bit 10 master, bit 9 transmit, bit 2 repeat, bit 1 stop and bit 0 start. While a transfer is active, a control write with enable set can only set the stop bit.
- R2: A control write in idle with enable, master and start set raises a bus request with operation 0 (start), carrying the target address and a read flag equal to the inverted transmit bit. It reloads the working count from the programmed count, and the start bit clears once the address phase is done. Operation codes are 0 start, 1 send, 2 receive, 3 stop.
- R3: An address phase that is not acknowledged sets the NACK event, clears the start, stop and master bits, and issues no further operation.
- R4: In normal transmit, bytes are sent in queue order while the working count is nonzero and the transmit queue holds data. Each sent byte decrements the working count. When data is still needed and the queue is empty, XRDY is set.
- R5: In normal receive, bytes are received while the working count is nonzero and the four-entry receive queue has room. RRDY is high exactly while the receive queue holds data.
- R6: When the count is exhausted with stop set, a stop operation is issued. When it completes, stop and master clear, the working count is reloaded and ARDY is set.
- R7: When the count is exhausted without stop, ARDY is set and master clears, and no stop operation is issued.
- R8: In repeat mode the count is neither checked nor decremented. A transmit step sends all queued bytes and then sets XRDY. A pending stop ends the transfer with a stop operation that clears stop and master and does not set ARDY.
- R9: A data byte that is not acknowledged sets NACK, clears stop and master, and ends the transfer without a stop operation.
- R10: Writing a 1 to bit 0 of the status-clear input clears NACK, and writing a 1 to bit 1 clears ARDY. A push into the transmit queue clears XRDY.
- R11: A control write with enable clear resets the sequencer to idle. It empties both queues, clears all events and the working count, and stores the masked control value.
- R12: A bus request and its operation stay stable until the cycle of the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_q | output | 16 | Control word readback |
| cnt_we | input | 1 | Programmed byte count write strobe |
| cnt_wdata | input | CNT_W | Programmed byte count value |
| cnt_q | output | CNT_W | Working byte count |
| tgt_addr | input | 7 | Target device address |
| stat_clr | input | 2 | Write-1 clear: bit 0 NACK, bit 1 ARDY |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_byte | input | 8 | Byte to push |
| tx_level | output | LVL_W | Transmit queue fill level |
| rx_pop | input | 1 | Pop the receive queue head |
| rx_byte | output | 8 | Receive queue head |
| rx_level | output | LVL_W | Receive queue fill level |
| bus_req | output | 1 | Request to the bus engine |
| bus_op | output | 2 | Requested operation code |
| bus_addr | output | 7 | Address for a start operation |
| bus_rw | output | 1 | 1 = read transfer |
| bus_wdata | output | 8 | Byte for a send operation |
| bus_done | input | 1 | One-cycle completion pulse |
| bus_ack | input | 1 | Acknowledge seen during the operation |
| bus_rdata | input | 8 | Byte returned by a receive operation |
| ev_nack | output | 1 | Missing acknowledge event |
| ev_xrdy | output | 1 | Transmit data wanted |
| ev_rrdy | output | 1 | Receive data available |
| ev_ardy | output | 1 | Access ready |

## Verification
The bench drives a behavioural bus engine that logs every operation, address and byte, and compares the logged sequence against each scenario. A transmit with all bytes queued ahead of time shows the count-driven stop path. A transmit that is one byte short shows XRDY stalling and the resume on a push. A five-byte receive against a four-entry queue shows the back-pressure stall, followed by the finish without a stop. An address refusal and a mid-stream byte refusal tell the two NACK exits apart. A repeat-mode transmit with more bytes than the count shows that the count is ignored, and an all-ones control write then a disable check the mask, the immediate stop and the reset.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_RUN,
    S_XFER,
    S_STOP
  } seq_state_e;

  localparam int CB_EN  = 15;
  localparam int CB_MST = 10;
  localparam int CB_TRX = 9;
  localparam int CB_RM  = 2;
  localparam int CB_STP = 1;
  localparam int CB_STT = 0;
  localparam logic [15:0] CTL_KEEP = 16'hcf87;
endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          wr_en, rd_en;

  assign full  = (lvl_q == LW'(DEPTH));
  assign empty = (lvl_q == '0);
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;
  assign dout  = mem[rp_q];
  assign level = lvl_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (wr_en) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (rd_en) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      if (wr_en && !rd_en)      lvl_d = lvl_q + LW'(1);
      else if (rd_en && !wr_en) lvl_d = lvl_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wp_q] <= din;
  end

  // R5: queue never reports more entries than it holds
  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
  import i2cseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  output logic [15:0]      ctl_q,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  input  logic [1:0]       stat_clr,
  input  logic             tx_push,
  input  logic             tx_empty,
  input  logic             rx_empty,
  input  logic             rx_full,
  output logic             tx_pop,
  output logic             rx_push,
  output logic             buf_clr,
  output logic             bus_req,
  output bus_op_e          bus_op,
  input  logic             bus_done,
  input  logic             bus_ack,
  output logic             ev_nack,
  output logic             ev_xrdy,
  output logic             ev_ardy
);
  seq_state_e       state_q, state_d;
  bus_op_e          op_q, op_d;
  logic [15:0]      ctl_r, ctl_d;
  logic [CNT_W-1:0] cur_q, cur_d, prog_q;
  logic             nack_q, nack_d, ardy_q, ardy_d, xrdy_q, xrdy_d;
  logic             rm, trx, disable_wr;

  assign rm         = ctl_r[CB_RM];
  assign trx        = ctl_r[CB_TRX];
  assign disable_wr = ctl_we && !ctl_wdata[CB_EN];

  assign ctl_q   = ctl_r;
  assign cnt_q   = cur_q;
  assign bus_op  = op_q;
  assign bus_req = (state_q == S_ADDR) || (state_q == S_XFER) || (state_q == S_STOP);
  assign ev_nack = nack_q;
  assign ev_ardy = ardy_q;
  assign ev_xrdy = xrdy_q;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    ctl_d   = ctl_r;
    cur_d   = cur_q;
    nack_d  = nack_q && !stat_clr[0];
    ardy_d  = ardy_q && !stat_clr[1];
    xrdy_d  = xrdy_q && !tx_push;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    buf_clr = 1'b0;
    if (disable_wr) begin
      state_d = S_IDLE;
      ctl_d   = ctl_wdata & CTL_KEEP;
      cur_d   = '0;
      nack_d  = 1'b0;
      ardy_d  = 1'b0;
      xrdy_d  = 1'b0;
      buf_clr = 1'b1;
    end else begin
      if (ctl_we && state_q != S_IDLE) ctl_d[CB_STP] = ctl_r[CB_STP] | ctl_wdata[CB_STP];
      unique case (state_q)
        S_IDLE: begin
          if (ctl_we) begin
            ctl_d = ctl_wdata & CTL_KEEP;
            if (ctl_wdata[CB_STT] && ctl_wdata[CB_MST]) begin
              state_d = S_ADDR;
              op_d    = OP_START;
              cur_d   = prog_q;
            end
          end
        end
        S_ADDR: begin
          if (bus_done) begin
            ctl_d[CB_STT] = 1'b0;
            if (!bus_ack) begin
              nack_d        = 1'b1;
              ctl_d[CB_STP] = 1'b0;
              ctl_d[CB_MST] = 1'b0;
              state_d       = S_IDLE;
            end else begin
              state_d = S_RUN;
            end
          end
        end
        S_RUN: begin
          if (rm) begin
            if (ctl_r[CB_STP]) begin
              op_d = OP_STOP; state_d = S_STOP;
            end else if (trx) begin
              if (!tx_empty) begin op_d = OP_SEND; state_d = S_XFER; end
              else xrdy_d = !tx_push;
            end else if (rx_empty) begin
              op_d = OP_RECV; state_d = S_XFER;
            end
          end else if (cur_q == '0) begin
            if (ctl_r[CB_STP]) begin
              op_d = OP_STOP; state_d = S_STOP;
            end else begin
              ardy_d        = 1'b1;
              ctl_d[CB_MST] = 1'b0;
              state_d       = S_IDLE;
            end
          end else if (trx) begin
            if (!tx_empty) begin op_d = OP_SEND; state_d = S_XFER; end
            else xrdy_d = !tx_push;
          end else if (!rx_full) begin
            op_d = OP_RECV; state_d = S_XFER;
          end
        end
        S_XFER: begin
          if (bus_done) begin
            if (!rm) cur_d = cur_q - CNT_W'(1);
            state_d = S_RUN;
            if (op_q == OP_SEND) begin
              tx_pop = 1'b1;
              if (!bus_ack) begin
                nack_d        = 1'b1;
                ctl_d[CB_STP] = 1'b0;
                ctl_d[CB_MST] = 1'b0;
                state_d       = S_IDLE;
              end
            end else begin
              rx_push = 1'b1;
            end
          end
        end
        S_STOP: begin
          if (bus_done) begin
            ctl_d[CB_STP] = 1'b0;
            ctl_d[CB_MST] = 1'b0;
            cur_d         = prog_q;
            if (!rm) ardy_d = 1'b1;
            state_d = S_IDLE;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_START;
      ctl_r   <= '0;
      cur_q   <= '0;
      nack_q  <= 1'b0;
      ardy_q  <= 1'b0;
      xrdy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      ctl_r   <= ctl_d;
      cur_q   <= cur_d;
      nack_q  <= nack_d;
      ardy_q  <= ardy_d;
      xrdy_q  <= xrdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prog_q <= '0;
    else if (cnt_we) prog_q <= cnt_wdata;
  end

  // R12: request and operation held until done
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done && !disable_wr) |=> (bus_req && $stable(bus_op)));
  // R4: a normal-mode send only with count left and data queued
  p_send_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == OP_SEND) |-> (!tx_empty && (rm || cur_q != '0)));
  // R5: a receive only with room in the queue
  p_recv_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == OP_RECV) |-> !rx_full);
  // R3: refused address ends the transfer with NACK
  p_addr_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == OP_START && bus_done && !bus_ack && !disable_wr && !stat_clr[0])
      |=> (ev_nack && !bus_req && !ctl_r[CB_STT]));
  // R2: start bit cleared after an accepted address phase
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == OP_START && bus_done && !disable_wr) |=> !ctl_r[CB_STT]);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2cseq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  output logic [15:0]      ctl_q,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  input  logic [6:0]       tgt_addr,
  input  logic [1:0]       stat_clr,
  input  logic             tx_push,
  input  logic [7:0]       tx_byte,
  output logic [LVL_W-1:0] tx_level,
  input  logic             rx_pop,
  output logic [7:0]       rx_byte,
  output logic [LVL_W-1:0] rx_level,
  output logic             bus_req,
  output logic [1:0]       bus_op,
  output logic [6:0]       bus_addr,
  output logic             bus_rw,
  output logic [7:0]       bus_wdata,
  input  logic             bus_done,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  output logic             ev_nack,
  output logic             ev_xrdy,
  output logic             ev_rrdy,
  output logic             ev_ardy
);
  logic    tx_pop, rx_push, buf_clr;
  logic    tx_full, tx_empty, rx_full, rx_empty;
  bus_op_e op_e;

  assign bus_op   = op_e;
  assign bus_addr = tgt_addr;
  assign bus_rw   = !ctl_q[CB_TRX];
  assign ev_rrdy  = !rx_empty;

  i2cseq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
    .stat_clr(stat_clr), .tx_push(tx_push),
    .tx_empty(tx_empty), .rx_empty(rx_empty), .rx_full(rx_full),
    .tx_pop(tx_pop), .rx_push(rx_push), .buf_clr(buf_clr),
    .bus_req(bus_req), .bus_op(op_e), .bus_done(bus_done), .bus_ack(bus_ack),
    .ev_nack(ev_nack), .ev_xrdy(ev_xrdy), .ev_ardy(ev_ardy)
  );

  i2cseq_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .push(tx_push), .din(tx_byte), .pop(tx_pop), .dout(bus_wdata),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  i2cseq_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .push(rx_push), .din(bus_rdata), .pop(rx_pop), .dout(rx_byte),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  // R11: a disabling control write leaves both queues empty
  p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[CB_EN]) |=> (tx_level == '0 && rx_level == '0 && !ev_nack && !ev_ardy));
  // R5: a full receive queue is never written past
  p_rx_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !(bus_req && bus_op == 2'd2));
  wire unused_full = tx_full;
endmodule

// File: tb/i2c_xfer_seq_test.sv
module i2c_xfer_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200,
                          RM = 16'h0004, STP = 16'h0002, STT = 16'h0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, cnt_we = 0, tx_push = 0, rx_pop = 0;
  logic [15:0] ctl_wdata = '0, cnt_wdata = '0;
  logic [15:0] ctl_q, cnt_q;
  logic [6:0]  tgt_addr = 7'h52;
  logic [1:0]  stat_clr = '0;
  logic [7:0]  tx_byte = '0, rx_byte, bus_wdata, bus_rdata = '0;
  logic [2:0]  tx_level, rx_level;
  logic        bus_req, bus_rw, bus_done = 0, bus_ack = 0;
  logic [1:0]  bus_op;
  logic [6:0]  bus_addr;
  logic        ev_nack, ev_xrdy, ev_rrdy, ev_ardy;

  int errors = 0, checks = 0;
  int n_ops = 0, wait_n = 0, send_idx = 0, nack_at = -1;
  logic addr_ack = 1'b1;
  logic [7:0] rd_next = 8'hA0;
  logic [1:0] op_log [32];
  logic [7:0] dat_log [32];
  logic [7:0] start_info;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .tgt_addr(tgt_addr),
    .stat_clr(stat_clr), .tx_push(tx_push), .tx_byte(tx_byte), .tx_level(tx_level),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_level(rx_level),
    .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .ev_nack(ev_nack), .ev_xrdy(ev_xrdy), .ev_rrdy(ev_rrdy), .ev_ardy(ev_ardy)
  );

  // behavioural bus engine: answers each request after a short delay
  always @(negedge clk) begin
    if (bus_done) bus_done = 1'b0;
    else if (!rst_n || !bus_req) wait_n = 0;
    else if (wait_n < 2) wait_n++;
    else begin
      wait_n = 0;
      bus_done = 1'b1;
      op_log[n_ops] = bus_op;
      dat_log[n_ops] = bus_wdata;
      if (bus_op == 2'd0) begin
        start_info = {bus_addr, bus_rw};
        bus_ack = addr_ack;
      end else if (bus_op == 2'd1) begin
        bus_ack = (send_idx != nack_at);
        send_idx++;
      end else if (bus_op == 2'd2) begin
        bus_rdata = rd_next;
        rd_next = rd_next + 8'd1;
        bus_ack = 1'b1;
      end else bus_ack = 1'b1;
      n_ops++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    ctl_wdata = v; ctl_we = 1'b1; cyc(1); ctl_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_wdata = v; cnt_we = 1'b1; cyc(1); cnt_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    tx_byte = b; tx_push = 1'b1; cyc(1); tx_push = 1'b0;
  endtask

  task automatic pop();
    rx_pop = 1'b1; cyc(1); rx_pop = 1'b0;
  endtask

  task automatic clr(input logic [1:0] m);
    stat_clr = m; cyc(1); stat_clr = 2'b00;
  endtask

  task automatic restart();
    rst_n = 1'b0; cyc(2);
    n_ops = 0; send_idx = 0; nack_at = -1; addr_ack = 1'b1; rd_next = 8'hA0;
    rst_n = 1'b1; cyc(2);
  endtask

  task automatic t_reset();
    restart();
    chk("R11 reset ctl", ctl_q, 0);
    chk("R11 reset cnt", cnt_q, 0);
    chk("R11 reset events", {ev_nack, ev_xrdy, ev_rrdy, ev_ardy}, 0);
    chk("R12 reset req", bus_req, 0);
    chk("R11 reset levels", {tx_level, rx_level}, 0);
  endtask

  task automatic t_tx_stop();
    restart();
    wr_cnt(3); push(8'hAA); push(8'hBB); push(8'hCC);
    wr_ctl(EN | MST | TRX | STP | STT);
    cyc(80);
    chk("R2 op count", n_ops, 5);
    chk("R2 start op", op_log[0], 0);
    chk("R2 addr/rw", start_info, {7'h52, 1'b0});
    chk("R4 sends", {op_log[1], op_log[2], op_log[3]}, 6'b010101);
    chk("R4 byte order", {dat_log[1], dat_log[2], dat_log[3]}, 24'hAABBCC);
    chk("R6 stop op", op_log[4], 3);
    chk("R6 ardy", ev_ardy, 1);
    chk("R6 ctl bits cleared", ctl_q, EN | TRX);
    chk("R6 count reloaded", cnt_q, 3);
    chk("R4 no xrdy", ev_xrdy, 0);
  endtask

  task automatic t_tx_short();
    restart();
    wr_cnt(3); push(8'h11); push(8'h22);
    wr_ctl(EN | MST | TRX | STT);
    cyc(60);
    chk("R4 stalled ops", n_ops, 3);
    chk("R4 xrdy", ev_xrdy, 1);
    chk("R4 count left", cnt_q, 1);
    push(8'h33);
    chk("R10 xrdy cleared by push", ev_xrdy, 0);
    cyc(40);
    chk("R7 no stop", n_ops, 4);
    chk("R7 last byte", dat_log[3], 8'h33);
    chk("R7 ardy", ev_ardy, 1);
    chk("R7 master cleared", ctl_q, EN | TRX);
    clr(2'b10);
    chk("R10 ardy cleared", ev_ardy, 0);
  endtask

  task automatic t_rx();
    restart();
    wr_cnt(5);
    wr_ctl(EN | MST | STT);
    cyc(80);
    chk("R2 rw read", start_info[0], 1);
    chk("R5 queue full", rx_level, 4);
    chk("R5 count left", cnt_q, 1);
    chk("R5 rrdy", ev_rrdy, 1);
    chk("R5 head", rx_byte, 8'hA0);
    pop();
    cyc(40);
    chk("R5 fifth byte", rx_level, 4);
    chk("R7 rx ops no stop", n_ops, 6);
    chk("R7 rx ardy", ev_ardy, 1);
    for (int i = 1; i < 5; i++) begin
      chk("R5 data", rx_byte, 8'hA0 + i[7:0]);
      pop();
    end
    chk("R5 rrdy low when empty", ev_rrdy, 0);
  endtask

  task automatic t_addr_nack();
    restart();
    addr_ack = 1'b0;
    wr_cnt(2); push(8'h01); push(8'h02);
    wr_ctl(EN | MST | TRX | STP | STT);
    cyc(50);
    chk("R3 single op", n_ops, 1);
    chk("R3 nack", ev_nack, 1);
    chk("R3 ctl cleared", ctl_q, EN | TRX);
    chk("R3 data untouched", tx_level, 2);
    clr(2'b01);
    chk("R10 nack cleared", ev_nack, 0);
  endtask

  task automatic t_data_nack();
    restart();
    nack_at = 1;
    wr_cnt(3); push(8'h01); push(8'h02); push(8'h03);
    wr_ctl(EN | MST | TRX | STP | STT);
    cyc(80);
    chk("R9 ops", n_ops, 3);
    chk("R9 nack", ev_nack, 1);
    chk("R9 ctl", ctl_q, EN | TRX);
    chk("R9 no ardy", ev_ardy, 0);
  endtask

  task automatic t_repeat();
    restart();
    wr_cnt(1); push(8'h0A); push(8'h0B); push(8'h0C);
    wr_ctl(EN | MST | TRX | RM | STT);
    cyc(80);
    chk("R8 sends ignore count", n_ops, 4);
    chk("R8 xrdy", ev_xrdy, 1);
    chk("R8 count kept", cnt_q, 1);
    chk("R8 still master", ctl_q, EN | MST | TRX | RM);
    wr_ctl(EN | MST | TRX | RM | STP);
    cyc(30);
    chk("R8 stop op", {n_ops[7:0], 6'd0, op_log[4]}, {8'd5, 8'd3});
    chk("R8 no ardy", ev_ardy, 0);
    chk("R8 ctl after stop", ctl_q, EN | TRX | RM);
  endtask

  task automatic t_mask_disable();
    restart();
    push(8'h55); push(8'h66);
    wr_ctl(16'hFFFF);
    cyc(50);
    chk("R1 mask and repeat stop", ctl_q, 16'hcb84);
    chk("R8 immediate stop", n_ops, 2);
    wr_ctl(16'h0000);
    chk("R11 queue emptied", tx_level, 0);
    chk("R11 ctl", ctl_q, 0);
    wr_cnt(0);
    wr_ctl(EN | MST | TRX | STP | STT);
    cyc(40);
    chk("R6 zero count stop", n_ops, 4);
    chk("R6 ardy after zero count", ev_ardy, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_tx_stop();
    t_tx_short();
    t_rx();
    t_addr_nack();
    t_data_nack();
    t_repeat();
    t_mask_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule